// File: doc/BRIEF.md
# Card-Memory DMA Mover with Address Translation

This block copies a run of byte beats between a system-memory port and a card-memory port. It is programmed through three registers: a control byte, a 16-bit start register and an 8-bit nibble register. The start register counts in 16-byte paragraphs and the nibble register supplies the byte offset within a paragraph. On 16-bit channels the card-side address is remapped: bits 19:18 stay where they are and paragraph bits 16:4 are doubled. On uploads to card memory the block can flip the sign bit of every sample byte. When a run ends, the start and nibble registers advance by the run length, so that back-to-back runs continue where the last one stopped.

An outside DMA controller starts a run with a length and a terminal-count flag. The engine moves one beat per clock. A beat is one byte on an 8-bit channel and two bytes on a 16-bit channel. Busy is high for exactly that many cycles and done pulses once afterwards. On terminal count the request bit is dropped and, if enabled, a terminal-count interrupt is posted. Software acknowledges it by reading the control register, and that read has side effects.

Top module: `dma_xlate_engine`

## Requirements
- R1: On an 8-bit channel (wide16=0), beat i of a run goes to card address start*16 + nibble[3:0] + i and to system address i. Only the low byte lane is used (be=2'b01).
- R2: On a 16-bit channel (wide16=1), the card base is L[19:18] kept in place plus 2*(L[16:4]*16), where L = start*16 + nibble[3:0]. Beat i goes to base + 2i and to system address 2i, with both lanes written (be=2'b11).
- R3: With control bit 1 = 0 (system to card), the sign mask is 8'h80 when control bit 7 is 1 and 0 otherwise. The high byte is always XORed with the mask. The low byte is copied unchanged when control bit 6 is 1 and is XORed with the mask otherwise.
- R4: With control bit 1 = 1 (card to system), data is read from card memory and written to system memory unchanged, whatever control bit 7 holds.
- R5: When a run of N beats ends, start becomes start + N/16 (integer division) and the nibble register becomes (N + old nibble[3:0]) mod 16, with its upper nibble zero.
- R6: Control bit 0 drives the dreq output. A run ended with the terminal-count flag clears it. A run without the flag leaves it set.
- R7: A terminal-count end with control bit 5 set raises tc_pend and irq. With control bit 5 clear, neither rises.
- R8: The control read value is the stored byte with bit 2 forced to 1 when wide16=1 and bit 6 forced to 1 while tc_pend is set. The read clears tc_pend. irq = tc_pend OR any bit of ext_stat.
- R9: A control read clears stored control bits 2 and 6. Other stored bits are kept.
- R10: A write to the start register clears nibble register bits 7:4 and keeps bits 3:0.
- R11: A run of N beats (N>0) accepted while idle keeps busy high for exactly N cycles, one write per cycle. Done is high for the single cycle after the last beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wide16 | input | 1 | 1 selects the 16-bit channel mode |
| ext_stat | input | 7 | Other interrupt status bits sharing the line |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_rd | input | 1 | Control register read strobe (side effects at the clock edge) |
| ctl_wdata | input | 8 | Control write data |
| ctl_rdata | output | 8 | Control read value, valid while ctl_rd is high |
| dreq | output | 1 | DMA request, stored control bit 0 |
| start_wr | input | 1 | Start register write strobe |
| start_wdata | input | 16 | Start register write data (paragraphs) |
| start_rdata | output | 16 | Current start register |
| nib_wr | input | 1 | Nibble register write strobe |
| nib_wdata | input | 8 | Nibble register write data |
| nib_rdata | output | 8 | Current nibble register |
| xfer_start | input | 1 | Begin a run (taken when idle and count is nonzero) |
| xfer_count | input | CNT_W | Number of beats in the run |
| xfer_tc | input | 1 | The run ends at terminal count |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse after the last beat |
| sys_addr | output | CNT_W+1 | System memory byte offset |
| sys_rdata | input | 16 | System read data, {byte at addr+1, byte at addr} |
| sys_wdata | output | 16 | System write data |
| sys_be | output | 2 | System byte-lane enables |
| sys_we | output | 1 | System write enable |
| card_addr | output | 20 | Card memory byte address |
| card_rdata | input | 16 | Card read data, {byte at addr+1, byte at addr} |
| card_wdata | output | 16 | Card write data |
| card_be | output | 2 | Card byte-lane enables |
| card_we | output | 1 | Card write enable |
| tc_pend | output | 1 | Terminal-count interrupt pending (status bit 7) |
| irq | output | 1 | Interrupt line |

## Verification
The bench targets the 16-bit remap at a start value whose bit 16 and bits 19:18 are both nonzero. A design that shifts the whole address, or that keeps the low nibble, would write to the wrong card addresses. Sign inversion is checked in all three relevant settings: low byte passed through, both bytes flipped, and card-to-system with the invert bit set. A missing direction gate would corrupt downloads. Runs with lengths that cross a paragraph boundary show whether the nibble carry is lost. Control reads check the pending flag: it must read back exactly once, it must drop irq only when no other status bit is set, and stored bit 6 must not read back again after the first read.

// File: rtl/dma_xlate_pkg.sv
package dma_xlate_pkg;
  localparam int START_W = 16;
  localparam int CARD_AW = START_W + 4;

  // Linear card address: paragraphs * 16 + byte offset.
  function automatic logic [CARD_AW-1:0] lin_addr(input logic [START_W-1:0] st,
                                                  input logic [3:0] nb);
    return {st, 4'h0} + {{START_W{1'b0}}, nb};
  endfunction

  // 16-bit channel remap: keep the top two bits, double paragraph bits 16:4.
  function automatic logic [CARD_AW-1:0] card_base(input logic [START_W-1:0] st,
                                                   input logic [3:0] nb,
                                                   input logic wide);
    logic [CARD_AW-1:0] l;
    l = lin_addr(st, nb);
    if (wide) return {l[19:18], l[16:4], 5'b0};
    return l;
  endfunction

  function automatic logic [7:0] sign_mask(input logic inv_en, input logic to_sys);
    return (inv_en && !to_sys) ? 8'h80 : 8'h00;
  endfunction

  function automatic logic [15:0] shape_beat(input logic [15:0] src,
                                             input logic [7:0] mask,
                                             input logic lo_pass);
    return {src[15:8] ^ mask, lo_pass ? src[7:0] : (src[7:0] ^ mask)};
  endfunction
endpackage

// File: rtl/dma_ctl_regs.sv
module dma_ctl_regs (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wide16,
  input  logic [6:0] ext_stat,
  input  logic       ctl_wr,
  input  logic       ctl_rd,
  input  logic [7:0] ctl_wdata,
  input  logic       tc_hit,
  output logic [7:0] ctl_q,
  output logic [7:0] ctl_rdata,
  output logic       tc_pend,
  output logic       irq
);
  logic [7:0] ctl_nxt;
  logic       pend_set_w;
  logic       pend_ack_w;

  assign pend_set_w = tc_hit && ctl_q[5];
  assign pend_ack_w = ctl_rd;

  always_comb begin
    ctl_nxt = ctl_q;
    if (ctl_rd) ctl_nxt = ctl_nxt & 8'hBB;
    if (tc_hit) ctl_nxt[0] = 1'b0;
    if (ctl_wr) ctl_nxt = ctl_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q   <= 8'h00;
      tc_pend <= 1'b0;
    end else begin
      ctl_q <= ctl_nxt;
      if (pend_set_w)      tc_pend <= 1'b1;
      else if (pend_ack_w) tc_pend <= 1'b0;
    end
  end

  assign ctl_rdata = ctl_q | {1'b0, tc_pend, 3'b000, wide16, 2'b00};
  assign irq       = tc_pend | (|ext_stat);

  p_tc_drops_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tc_hit && !ctl_wr |=> !ctl_q[0]);
  p_tc_posts_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tc_hit && ctl_q[5] |=> tc_pend && irq);
  p_read_acks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rd && !tc_hit |=> !tc_pend);
  p_read_clears_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rd && !ctl_wr |=> ctl_q[2] == 1'b0 && ctl_q[6] == 1'b0);
endmodule

// File: rtl/dma_addr_regs.sv
module dma_addr_regs
  import dma_xlate_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wide16,
  input  logic               start_wr,
  input  logic [START_W-1:0] start_wdata,
  input  logic               nib_wr,
  input  logic [7:0]         nib_wdata,
  input  logic               finish,
  input  logic [CNT_W-1:0]   run_len,
  output logic [START_W-1:0] start_q,
  output logic [7:0]         nib_q,
  output logic [CARD_AW-1:0] base
);
  logic [START_W-1:0] para_adv_w;
  logic [3:0]         nib_adv_w;

  assign para_adv_w = START_W'(run_len >> 4);
  assign nib_adv_w  = run_len[3:0] + nib_q[3:0];
  assign base       = card_base(start_q, nib_q[3:0], wide16);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= '0;
      nib_q   <= 8'h00;
    end else if (finish) begin
      start_q <= start_q + para_adv_w;
      nib_q   <= {4'h0, nib_adv_w};
    end else begin
      if (start_wr) begin
        start_q <= start_wdata;
        nib_q   <= {4'h0, (nib_wr ? nib_wdata[3:0] : nib_q[3:0])};
      end else if (nib_wr) begin
        nib_q   <= nib_wdata;
      end
    end
  end

  p_start_wr_clears_hi_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start_wr && !finish |=> nib_q[7:4] == 4'h0);
  p_finish_nib_r5: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> nib_q == {4'h0, $past(nib_adv_w)});
endmodule

// File: rtl/dma_mover.sv
module dma_mover
  import dma_xlate_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               xfer_start,
  input  logic [CNT_W-1:0]   xfer_count,
  input  logic               xfer_tc,
  input  logic               wide16,
  input  logic [CARD_AW-1:0] base,
  input  logic [7:0]         ctl_q,
  input  logic [15:0]        sys_rdata,
  input  logic [15:0]        card_rdata,
  output logic               busy,
  output logic               done,
  output logic               finish,
  output logic               tc_hit,
  output logic [CNT_W-1:0]   run_len,
  output logic [CNT_W:0]     sys_addr,
  output logic [15:0]        sys_wdata,
  output logic [1:0]         sys_be,
  output logic               sys_we,
  output logic [CARD_AW-1:0] card_addr,
  output logic [15:0]        card_wdata,
  output logic [1:0]         card_be,
  output logic               card_we
);
  localparam int OFF_W = CNT_W + 1;

  logic [CNT_W-1:0]   beat_q;
  logic               tc_q;
  logic               wide_q;
  logic [CARD_AW-1:0] base_q;
  logic               accept_w;
  logic               last_w;
  logic [OFF_W-1:0]   off_w;
  logic               to_sys_w;
  logic [7:0]         mask_w;
  logic [15:0]        beat_w;

  assign accept_w = xfer_start && !busy && (xfer_count != '0);
  assign last_w   = busy && (beat_q == run_len - 1'b1);
  assign off_w    = wide_q ? {beat_q, 1'b0} : {1'b0, beat_q};
  assign to_sys_w = ctl_q[1];
  assign mask_w   = sign_mask(ctl_q[7], to_sys_w);
  assign beat_w   = shape_beat(to_sys_w ? card_rdata : sys_rdata, mask_w, ctl_q[6]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      beat_q  <= '0;
      run_len <= '0;
      tc_q    <= 1'b0;
      wide_q  <= 1'b0;
      base_q  <= '0;
    end else begin
      done <= last_w;
      if (accept_w) begin
        busy    <= 1'b1;
        beat_q  <= '0;
        run_len <= xfer_count;
        tc_q    <= xfer_tc;
        wide_q  <= wide16;
        base_q  <= base;
      end else if (busy) begin
        beat_q <= beat_q + 1'b1;
        if (last_w) busy <= 1'b0;
      end
    end
  end

  assign finish     = last_w;
  assign tc_hit     = last_w && tc_q;
  assign sys_addr   = off_w;
  assign card_addr  = base_q + CARD_AW'(off_w);
  assign card_wdata = beat_w;
  assign sys_wdata  = beat_w;
  assign card_be    = {wide_q, 1'b1};
  assign sys_be     = {wide_q, 1'b1};
  assign card_we    = busy && !to_sys_w;
  assign sys_we     = busy && to_sys_w;

  p_we_in_run_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (card_we || sys_we) |-> busy);
  p_done_after_run_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy));
  p_card_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |->
      card_addr == $past(card_addr) + {{(CARD_AW-2){1'b0}}, wide_q, ~wide_q});
  p_one_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({card_we, sys_we}));
endmodule

// File: rtl/dma_xlate_engine.sv
module dma_xlate_engine
  import dma_xlate_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wide16,
  input  logic [6:0]         ext_stat,
  input  logic               ctl_wr,
  input  logic               ctl_rd,
  input  logic [7:0]         ctl_wdata,
  output logic [7:0]         ctl_rdata,
  output logic               dreq,
  input  logic               start_wr,
  input  logic [15:0]        start_wdata,
  output logic [15:0]        start_rdata,
  input  logic               nib_wr,
  input  logic [7:0]         nib_wdata,
  output logic [7:0]         nib_rdata,
  input  logic               xfer_start,
  input  logic [CNT_W-1:0]   xfer_count,
  input  logic               xfer_tc,
  output logic               busy,
  output logic               done,
  output logic [CNT_W:0]     sys_addr,
  input  logic [15:0]        sys_rdata,
  output logic [15:0]        sys_wdata,
  output logic [1:0]         sys_be,
  output logic               sys_we,
  output logic [19:0]        card_addr,
  input  logic [15:0]        card_rdata,
  output logic [15:0]        card_wdata,
  output logic [1:0]         card_be,
  output logic               card_we,
  output logic               tc_pend,
  output logic               irq
);
  logic [7:0]         ctl_q;
  logic               finish_w;
  logic               tc_hit_w;
  logic [CNT_W-1:0]   run_len_w;
  logic [CARD_AW-1:0] base_w;

  dma_ctl_regs u_ctl (
    .clk(clk), .rst_n(rst_n), .wide16(wide16), .ext_stat(ext_stat),
    .ctl_wr(ctl_wr), .ctl_rd(ctl_rd), .ctl_wdata(ctl_wdata), .tc_hit(tc_hit_w),
    .ctl_q(ctl_q), .ctl_rdata(ctl_rdata), .tc_pend(tc_pend), .irq(irq)
  );

  dma_addr_regs #(.CNT_W(CNT_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .wide16(wide16),
    .start_wr(start_wr), .start_wdata(start_wdata),
    .nib_wr(nib_wr), .nib_wdata(nib_wdata),
    .finish(finish_w), .run_len(run_len_w),
    .start_q(start_rdata), .nib_q(nib_rdata), .base(base_w)
  );

  dma_mover #(.CNT_W(CNT_W)) u_mover (
    .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_count(xfer_count),
    .xfer_tc(xfer_tc), .wide16(wide16), .base(base_w), .ctl_q(ctl_q),
    .sys_rdata(sys_rdata), .card_rdata(card_rdata),
    .busy(busy), .done(done), .finish(finish_w), .tc_hit(tc_hit_w),
    .run_len(run_len_w), .sys_addr(sys_addr), .sys_wdata(sys_wdata),
    .sys_be(sys_be), .sys_we(sys_we), .card_addr(card_addr),
    .card_wdata(card_wdata), .card_be(card_be), .card_we(card_we)
  );

  assign dreq = ctl_q[0];

  p_no_request_after_tc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done && $past(tc_hit_w) && !$past(ctl_wr) |-> !dreq);
endmodule

// File: tb/tb_dma_xlate_engine.sv
module tb_dma_xlate_engine;
  localparam int CNT_W = 16;

  typedef struct packed {
    logic        to_sys;
    logic [19:0] addr;
    logic [15:0] data;
    logic [1:0]  be;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wide16 = 1'b0;
  logic [6:0] ext_stat = '0;
  logic ctl_wr = 1'b0, ctl_rd = 1'b0;
  logic [7:0] ctl_wdata = '0;
  logic [7:0] ctl_rdata;
  logic dreq;
  logic start_wr = 1'b0;
  logic [15:0] start_wdata = '0;
  logic [15:0] start_rdata;
  logic nib_wr = 1'b0;
  logic [7:0] nib_wdata = '0;
  logic [7:0] nib_rdata;
  logic xfer_start = 1'b0;
  logic [CNT_W-1:0] xfer_count = '0;
  logic xfer_tc = 1'b0;
  logic busy, done;
  logic [CNT_W:0] sys_addr;
  logic [15:0] sys_rdata, sys_wdata;
  logic [1:0] sys_be;
  logic sys_we;
  logic [19:0] card_addr;
  logic [15:0] card_rdata, card_wdata;
  logic [1:0] card_be;
  logic card_we;
  logic tc_pend, irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;
  item_t exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  function automatic logic [7:0] pat_s(input int a);
    return 8'((a * 7 + 19) & 255);
  endfunction
  function automatic logic [7:0] pat_c(input int a);
    return 8'(((a & 255) ^ 8'hC3) + ((a >> 8) & 15));
  endfunction

  assign sys_rdata  = {pat_s(int'(sys_addr) + 1), pat_s(int'(sys_addr))};
  assign card_rdata = {pat_c(int'(card_addr) + 1), pat_c(int'(card_addr))};

  dma_xlate_engine #(.CNT_W(CNT_W)) dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && (card_we || sys_we)) begin
      item_t got, want;
      string t;
      got.to_sys = sys_we;
      got.addr   = sys_we ? 20'(sys_addr) : card_addr;
      got.data   = sys_we ? sys_wdata : card_wdata;
      got.be     = sys_we ? sys_be : card_be;
      if (exp_q.size() == 0) begin
        check("R11 unexpected write", {11'h0, got.addr, got.to_sys}, 32'hFFFF_FFFF);
      end else begin
        want = exp_q.pop_front();
        t    = tag_q.pop_front();
        if (!got.be[1]) got.data[15:8] = 8'h00;
        check(t, {got.to_sys, got.be, got.addr, 9'h0}, {want.to_sys, want.be, want.addr, 9'h0});
        check(t, {16'h0, got.data}, {16'h0, want.data});
      end
    end
  end

  task automatic wr_ctl(input logic [7:0] v);
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_wr = 1'b0;
  endtask
  task automatic wr_start(input logic [15:0] v);
    @(negedge clk); start_wr = 1'b1; start_wdata = v;
    @(negedge clk); start_wr = 1'b0;
  endtask
  task automatic wr_nib(input logic [7:0] v);
    @(negedge clk); nib_wr = 1'b1; nib_wdata = v;
    @(negedge clk); nib_wr = 1'b0;
  endtask
  task automatic rd_ctl(output logic [7:0] v);
    @(negedge clk); ctl_rd = 1'b1;
    #2 v = ctl_rdata;
    @(negedge clk); ctl_rd = 1'b0;
  endtask

  // Own model of the card base address
  function automatic int exp_base(input int st, input int nb, input bit w);
    int l;
    l = st * 16 + (nb % 16);
    if (!w) return l % 1048576;
    return (l / 262144) * 262144 + 2 * (((l % 131072) / 16) * 16);
  endfunction

  task automatic run(input int cnt, input bit tc, input logic [7:0] ctl,
                     input string tag);
    int base, step, cyc, st0, nb0;
    st0  = int'(start_rdata);
    nb0  = int'(nib_rdata);
    base = exp_base(st0, nb0, wide16);
    step = wide16 ? 2 : 1;
    for (int i = 0; i < cnt; i++) begin
      item_t it;
      int off;
      logic [7:0] m, lo, hi;
      off = i * step;
      if (!ctl[1]) begin
        m  = ctl[7] ? 8'h80 : 8'h00;
        lo = pat_s(off); hi = pat_s(off + 1);
        it.to_sys = 1'b0;
        it.addr   = 20'(base + off);
        it.data   = {wide16 ? (hi ^ m) : 8'h00, ctl[6] ? lo : (lo ^ m)};
      end else begin
        it.to_sys = 1'b1;
        it.addr   = 20'(off);
        it.data   = {wide16 ? pat_c(base + off + 1) : 8'h00, pat_c(base + off)};
      end
      it.be = {wide16, 1'b1};
      exp_q.push_back(it);
      tag_q.push_back(tag);
    end
    @(negedge clk); xfer_start = 1'b1; xfer_count = CNT_W'(cnt); xfer_tc = tc;
    @(negedge clk); xfer_start = 1'b0;
    cyc = 0;
    while (busy) begin cyc++; @(negedge clk); end
    check("R11 busy cycles", cyc, cnt);
    check("R11 done pulse", {31'h0, done}, 1);
    @(negedge clk);
    check("R11 done single", {31'h0, done}, 0);
    check("R11 all writes seen", exp_q.size(), 0);
    check("R5 start advance", {16'h0, start_rdata}, 32'((st0 + cnt / 16) % 65536));
    check("R5 nibble advance", {24'h0, nib_rdata}, 32'((cnt + nb0) % 16));
  endtask

  initial begin
    #2000000;
    check("watchdog", 32'h0, 32'h1);
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    check("R6 reset dreq", {31'h0, dreq}, 0);
    check("R11 reset busy", {31'h0, busy}, 0);
    check("R7 reset irq", {30'h0, irq, tc_pend}, 0);
    check("R5 reset start", {16'h0, start_rdata}, 0);
    check("R8 reset ctl read", {24'h0, ctl_rdata}, 0);

    // R10: start write clears upper nibble only
    wr_nib(8'hA7);
    check("R10 nib written", {24'h0, nib_rdata}, 32'hA7);
    wr_start(16'h0123);
    check("R10 upper nibble cleared", {24'h0, nib_rdata}, 32'h07);

    // R1 R3: 8-bit upload with sign inversion, no TC
    wr_ctl(8'h81);
    run(5, 1'b0, 8'h81, "R1/R3 8-bit invert");
    check("R6 no tc keeps dreq", {31'h0, dreq}, 1);

    // R5: run crossing a paragraph, no inversion
    wr_nib(8'h0E);
    wr_start(16'h0100);
    wr_ctl(8'h01);
    run(37, 1'b0, 8'h01, "R1/R5 plain copy");

    // R2 R3: 16-bit, low byte passed, high inverted, TC without irq enable
    wide16 = 1'b1;
    wr_start(16'h5432);
    wr_nib(8'h03);
    wr_ctl(8'hC1);
    run(4, 1'b1, 8'hC1, "R2/R3 16-bit low pass");
    check("R6 tc clears dreq", {31'h0, dreq}, 0);
    check("R7 no irq when disabled", {30'h0, irq, tc_pend}, 0);

    // R2 R3: 16-bit, both bytes inverted
    wr_ctl(8'h81);
    run(3, 1'b0, 8'h81, "R2/R3 16-bit both invert");

    // R4 R7: card to system, invert bit ignored, TC with irq
    wide16 = 1'b0;
    wr_ctl(8'hA3);
    run(6, 1'b1, 8'hA3, "R4 download unchanged");
    check("R6 tc clears dreq", {31'h0, dreq}, 0);
    check("R7 tc irq pending", {30'h0, irq, tc_pend}, 3);

    // R8: acknowledge by read
    rd_ctl(v);
    check("R8 read shows pending", {24'h0, v}, 32'hE2);
    check("R8 irq dropped", {30'h0, irq, tc_pend}, 0);
    rd_ctl(v);
    check("R8 second read", {24'h0, v}, 32'hA2);
    wide16 = 1'b1;
    rd_ctl(v);
    check("R8 wide forces bit2", {24'h0, v}, 32'hA6);
    wide16 = 1'b0;
    rd_ctl(v);
    check("R9 bit2 not stored", {24'h0, v}, 32'hA2);

    // R9: stored bits 2 and 6 cleared by a read
    wr_ctl(8'h44);
    rd_ctl(v);
    check("R9 first read", {24'h0, v}, 32'h44);
    rd_ctl(v);
    check("R9 bits cleared", {24'h0, v}, 32'h00);

    // R8: other status keeps irq up
    ext_stat = 7'h04;
    wr_ctl(8'h21);
    run(2, 1'b1, 8'h21, "R1 short run");
    check("R7 pending set", {31'h0, tc_pend}, 1);
    rd_ctl(v);
    check("R8 read with pending", {24'h0, v}, 32'h60);
    check("R8 irq held by others", {30'h0, irq, tc_pend}, 2);
    ext_stat = 7'h00;
    @(negedge clk);
    check("R8 irq released", {31'h0, irq}, 0);

    // R11: start ignored with zero count
    @(negedge clk); xfer_start = 1'b1; xfer_count = '0;
    @(negedge clk); xfer_start = 1'b0;
    check("R11 zero count idle", {31'h0, busy}, 0);

    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule